// File: doc/BRIEF.md
# Machine Cycle Clock Mode Controller

This block decides how many input clocks make up one machine cycle of a processor core and issues a one-clock strobe at the end of every machine cycle. A 2-bit mode field selects between a frequency-multiplied rate (one or two clocks per cycle, set by a separate ratio-select bit), the divide-by-four rate that follows reset, and a slow power-saving rate of 1024 clocks per cycle. The analog multiplier is not modelled. In its place, a lock-up counter raises a ready flag a fixed number of clocks after the multiplier-enable bit is set.

Mode changes are guarded. The field may only move into or out of divide-by-four. A move into multiplier mode is accepted only after a specific order of writes has been seen while the block sits in divide-by-four with the regeneration-mode input low. Any write that breaks these rules is dropped without trace, and the field keeps its old value. A new rate is adopted only at a machine-cycle boundary, so no machine cycle is ever cut short.

Top module: `mc_clock_ctrl`

## Requirements
- R1: After reset the mode field reads 2'b10, the multiplier enable, ratio select and ready flag read 0, and a strobe arrives every 4 clocks.
- R2: Clocks per machine cycle are: mode 2'b10 gives 4, mode 2'b11 gives 1024, mode 2'b00 with ratio select 0 gives 2, and mode 2'b00 with ratio select 1 gives 1.
- R3: The strobe is a single-clock pulse whenever the period exceeds one clock. The machine cycle in progress once a mode write is registered ends at its old length, and the cycles after it use the new length. This holds even when the write lands in the same clock as a strobe.
- R4: Mode 2'b01 is never accepted. A change of mode is accepted only into or out of 2'b10. A rejected write leaves the readback and the strobe spacing unchanged.
- R5: A write of 2'b00 from 2'b10 is accepted only if these writes came first, in this order: enable written 0, then ratio select written, then enable written 1, with the ready flag at 1 when the 2'b00 write arrives. Rejected mode writes between the steps do not disturb this progress. Leaving 2'b00 for 2'b10 needs no preparation.
- R6: The arming progress returns to its start on any of these events: an enable-1 write that does not follow a select step, a select write that does not follow a clear step, a select write while enabled, the regeneration-mode input at 1, or the mode field leaving 2'b10. A 2'b00 request made after such an event is rejected.
- R7: The ready flag rises exactly LOCK_CYCLES clocks after the enable readback goes to 1. It is low by the second clock edge after the enable is written 0, and the count restarts from zero.
- R8: Ratio-select writes are ignored while the enable is 1, and enable writes are ignored while the mode field is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr_i | input | 1 | Write strobe for the mode field |
| div_wdata_i | input | 2 | Requested mode field value |
| mul_en_wr_i | input | 1 | Write strobe for the multiplier enable |
| mul_en_wdata_i | input | 1 | Requested multiplier enable value |
| sel_wr_i | input | 1 | Write strobe for the ratio select |
| sel_wdata_i | input | 1 | Requested ratio select (1 = one clock per cycle) |
| regen_i | input | 1 | Regeneration-mode status; high blocks arming |
| mc_strobe_o | output | 1 | Machine-cycle end strobe |
| mul_ready_o | output | 1 | Multiplier lock-up complete |
| div_o | output | 2 | Current mode field |
| mul_en_o | output | 1 | Current multiplier enable |
| sel4x_o | output | 1 | Current ratio select |

## Verification
Two functions can fall in the same clock: a mode-field write and the strobe that closes the current machine cycle. The bench waits until the strobe is visible and drives a divide-by-four to power-saving write in that same clock. It then counts clocks to the next strobe, which must still be four, and to the one after, which must be 1024. A second coincidence is a 2'b00 request issued before the ready flag rises. That request must be rejected, and the same request repeated after ready rises must be accepted without rearming.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        MODE_MUL  = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_DIV4 = 2'b10,
        MODE_PMM  = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        ARM_IDLE,
        ARM_CLEARED,
        ARM_SELECTED,
        ARM_ENABLED
    } arm_stage_e;

endpackage

// File: rtl/mcc_transition_chk.sv
module mcc_transition_chk
    import mcc_pkg::*;
(
    input  clk_mode_e  cur_i,
    input  clk_mode_e  req_i,
    input  logic       armed_i,
    output logic       legal_o
);

    always_comb begin
        legal_o = 1'b0;
        if (req_i == cur_i) begin
            legal_o = (req_i != MODE_RSVD);
        end else if (cur_i == MODE_DIV4) begin
            legal_o = (req_i == MODE_PMM) || ((req_i == MODE_MUL) && armed_i);
        end else if (req_i == MODE_DIV4) begin
            legal_o = (cur_i != MODE_RSVD);
        end
    end

endmodule

// File: rtl/mcc_lock_cnt.sv
module mcc_lock_cnt #(
    parameter int LOCK_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ready_o
);

    localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } lock_t;

    lock_t d, q;

    always_comb begin
        d = q;
        if (!en_i) begin
            d.cnt   = '0;
            d.ready = 1'b0;
        end else if (!q.ready) begin
            if (q.cnt == LAST) begin
                d.ready = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_o = q.ready;

endmodule

// File: rtl/mcc_arm_seq.sv
module mcc_arm_seq
    import mcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allowed_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic sel_wr_i,
    input  logic en_q_i,
    input  logic ready_i,
    output logic armed_o
);

    arm_stage_e stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (!allowed_i) begin
            stage_d = ARM_IDLE;
        end else if (en_wr_i && sel_wr_i) begin
            stage_d = ARM_IDLE;
        end else if (en_wr_i && !en_val_i) begin
            stage_d = ARM_CLEARED;
        end else if (en_wr_i) begin
            stage_d = (stage_q == ARM_SELECTED) ? ARM_ENABLED : ARM_IDLE;
        end else if (sel_wr_i) begin
            stage_d = ((stage_q == ARM_CLEARED) && !en_q_i) ? ARM_SELECTED : ARM_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ARM_IDLE;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign armed_o = (stage_q == ARM_ENABLED) && ready_i && allowed_i;

endmodule

// File: rtl/mcc_strobe_gen.sv
module mcc_strobe_gen #(
    parameter int PER_W        = 11,
    parameter int RESET_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic             strobe_o
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } strb_t;

    strb_t d, q;
    logic  last;

    always_comb begin
        last = (q.cnt == (q.per - PER_W'(1)));
        d    = q;
        if (last) begin
            d.cnt = '0;
            d.per = period_i;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.per <= PER_W'(RESET_PERIOD);
        end else begin
            q <= d;
        end
    end

    assign strobe_o = last;

endmodule

// File: rtl/mc_clock_ctrl.sv
module mc_clock_ctrl
    import mcc_pkg::*;
#(
    parameter int LOCK_CYCLES = 65536,
    parameter int PMM_CLKS    = 1024,
    parameter int DIV4_CLKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_wr_i,
    input  logic [1:0] div_wdata_i,
    input  logic       mul_en_wr_i,
    input  logic       mul_en_wdata_i,
    input  logic       sel_wr_i,
    input  logic       sel_wdata_i,
    input  logic       regen_i,
    output logic       mc_strobe_o,
    output logic       mul_ready_o,
    output logic [1:0] div_o,
    output logic       mul_en_o,
    output logic       sel4x_o
);

    localparam int PER_W = $clog2(PMM_CLKS + 1);

    typedef struct packed {
        clk_mode_e mode;
        logic      en;
        logic      sel;
    } ctl_t;

    ctl_t             d, q;
    logic             legal;
    logic             armed;
    logic             ready;
    logic             en_wr_ok;
    logic             arm_allowed;
    logic [PER_W-1:0] period;
    clk_mode_e        req_mode;

    assign req_mode    = clk_mode_e'(div_wdata_i);
    assign en_wr_ok    = mul_en_wr_i && (q.mode != MODE_MUL);
    assign arm_allowed = (q.mode == MODE_DIV4) && !regen_i;

    mcc_transition_chk u_trans (
        .cur_i   (q.mode),
        .req_i   (req_mode),
        .armed_i (armed),
        .legal_o (legal)
    );

    mcc_arm_seq u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .allowed_i (arm_allowed),
        .en_wr_i   (en_wr_ok),
        .en_val_i  (mul_en_wdata_i),
        .sel_wr_i  (sel_wr_i),
        .en_q_i    (q.en),
        .ready_i   (ready),
        .armed_o   (armed)
    );

    mcc_lock_cnt #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (q.en),
        .ready_o (ready)
    );

    always_comb begin
        d = q;
        if (div_wr_i && legal) begin
            d.mode = req_mode;
        end
        if (en_wr_ok) begin
            d.en = mul_en_wdata_i;
        end
        if (sel_wr_i && !q.en && (q.mode != MODE_MUL)) begin
            d.sel = sel_wdata_i;
        end
    end

    always_comb begin
        case (q.mode)
            MODE_MUL: period = q.sel ? PER_W'(1) : PER_W'(2);
            MODE_PMM: period = PER_W'(PMM_CLKS);
            default:  period = PER_W'(DIV4_CLKS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode <= MODE_DIV4;
            q.en   <= 1'b0;
            q.sel  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    mcc_strobe_gen #(
        .PER_W        (PER_W),
        .RESET_PERIOD (DIV4_CLKS)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period),
        .strobe_o (mc_strobe_o)
    );

    assign mul_ready_o = ready;
    assign div_o       = q.mode;
    assign mul_en_o    = q.en;
    assign sel4x_o     = q.sel;

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
    parameter int PMM_CLKS  = 1024,
    parameter int DIV4_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       regen_i,
    input logic       mc_strobe_o,
    input logic       mul_ready_o,
    input logic [1:0] div_o,
    input logic       mul_en_o
);

    logic [31:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (mc_strobe_o) begin
            since_q <= '0;
        end else begin
            since_q <= since_q + 1'b1;
        end
    end

    // R2: every strobe closes a machine cycle of a legal length
    a_r2_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mc_strobe_o |-> ((since_q + 1) == 1 || (since_q + 1) == 2 ||
                         (since_q + 1) == DIV4_CLKS || (since_q + 1) == PMM_CLKS));

    // R4: the reserved code never appears
    a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        div_o != 2'b01);

    // R4: every change of mode touches divide-by-four
    a_r4_via_div4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o != $past(div_o)) |-> ($past(div_o) == 2'b10 || div_o == 2'b10));

    // R5: entry to multiplier mode only with lock achieved and regeneration low
    a_r5_armed_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o == 2'b00 && $past(div_o) == 2'b10) |->
            ($past(mul_ready_o) && $past(mul_en_o) && !$past(regen_i)));

    // R8: enable cannot be dropped while multiplier mode is active
    a_r8_mul_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o == 2'b00) |-> (mul_en_o && mul_ready_o));

    // R7: ready only rises with the enable set
    a_r7_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mul_ready_o) |-> mul_en_o);

    // R7: dropping the enable clears ready on the following edge
    a_r7_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mul_en_o) |=> !mul_ready_o);

endmodule

bind mc_clock_ctrl mcc_checker #(
    .PMM_CLKS  (PMM_CLKS),
    .DIV4_CLKS (DIV4_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .regen_i     (regen_i),
    .mc_strobe_o (mc_strobe_o),
    .mul_ready_o (mul_ready_o),
    .div_o       (div_o),
    .mul_en_o    (mul_en_o)
);

// File: tb/mc_clock_ctrl_test.sv
`timescale 1ns/1ps
module mc_clock_ctrl_test;

    localparam int LOCK = 100;
    localparam int PMM  = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr_i = 1'b0;
    logic [1:0] div_wdata_i = 2'b00;
    logic       mul_en_wr_i = 1'b0;
    logic       mul_en_wdata_i = 1'b0;
    logic       sel_wr_i = 1'b0;
    logic       sel_wdata_i = 1'b0;
    logic       regen_i = 1'b0;
    logic       mc_strobe_o;
    logic       mul_ready_o;
    logic [1:0] div_o;
    logic       mul_en_o;
    logic       sel4x_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mc_clock_ctrl #(.LOCK_CYCLES(LOCK), .PMM_CLKS(PMM), .DIV4_CLKS(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .div_wr_i(div_wr_i), .div_wdata_i(div_wdata_i),
        .mul_en_wr_i(mul_en_wr_i), .mul_en_wdata_i(mul_en_wdata_i),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .regen_i(regen_i),
        .mc_strobe_o(mc_strobe_o), .mul_ready_o(mul_ready_o),
        .div_o(div_o), .mul_en_o(mul_en_o), .sel4x_o(sel4x_o)
    );

    // {write value, expected field, expected clocks per cycle}
    localparam logic [14:0] VEC [8] = '{
        {2'b01, 2'b10, 11'd4},
        {2'b11, 2'b11, 11'd1024},
        {2'b00, 2'b11, 11'd1024},
        {2'b01, 2'b11, 11'd1024},
        {2'b10, 2'b10, 11'd4},
        {2'b00, 2'b10, 11'd4},
        {2'b11, 2'b11, 11'd1024},
        {2'b10, 2'b10, 11'd4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr_div(input logic [1:0] v);
        @(negedge clk); div_wr_i = 1'b1; div_wdata_i = v;
        @(negedge clk); div_wr_i = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk); mul_en_wr_i = 1'b1; mul_en_wdata_i = v;
        @(negedge clk); mul_en_wr_i = 1'b0;
    endtask

    task automatic wr_sel(input logic v);
        @(negedge clk); sel_wr_i = 1'b1; sel_wdata_i = v;
        @(negedge clk); sel_wr_i = 1'b0;
    endtask

    // skip to the next strobe, then count clocks to the one after it
    task automatic gap(output int g);
        while (!mc_strobe_o) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!mc_strobe_o);
    endtask

    task automatic wait_ready(output int k);
        k = 0;
        while (!mul_ready_o && k < 4 * LOCK) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic arm(input logic s);
        int k;
        wr_en(1'b0);
        wr_sel(s);
        wr_en(1'b1);
        wait_ready(k);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin : main
        int g;
        int k;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(div_o == 2'b10, "R1", "reset field", div_o, 2);
        check(!mul_en_o && !sel4x_o && !mul_ready_o, "R1", "reset flags",
              {mul_en_o, sel4x_o, mul_ready_o}, 0);
        gap(g);
        check(g == 4, "R1", "reset period", g, 4);

        // R4 / R2 table of mode writes
        for (int i = 0; i < 8; i++) begin
            wr_div(VEC[i][14:13]);
            check(div_o == VEC[i][12:11], "R4", "field after write", div_o, VEC[i][12:11]);
            gap(g);
            check(g == int'(VEC[i][10:0]), "R2", "period after write", g, VEC[i][10:0]);
        end

        // R3 single-clock pulse in divide-by-four
        while (!mc_strobe_o) @(negedge clk);
        @(negedge clk);
        check(!mc_strobe_o, "R3", "strobe width", mc_strobe_o, 0);

        // R3 write in the same clock as a strobe
        while (!mc_strobe_o) @(negedge clk);
        div_wr_i = 1'b1; div_wdata_i = 2'b11;
        @(negedge clk); div_wr_i = 1'b0;
        g = 1;
        while (!mc_strobe_o) begin @(negedge clk); g++; end
        check(g == 4, "R3", "old cycle length after coincident write", g, 4);
        g = 0;
        do begin @(negedge clk); g++; end while (!mc_strobe_o);
        check(g == PMM, "R3", "new cycle length after coincident write", g, PMM);
        wr_div(2'b10);
        gap(g);
        check(g == 4, "R5", "leave power mode", g, 4);

        // R5 / R7 full arming with an unrelated rejected write between steps
        wr_en(1'b0);
        wr_div(2'b01);
        wr_sel(1'b0);
        wr_en(1'b1);
        check(!mul_ready_o, "R7", "ready low right after enable", mul_ready_o, 0);
        wait_ready(k);
        check(k == LOCK, "R7", "lock-up clocks", k, LOCK);
        wr_div(2'b00);
        check(div_o == 2'b00, "R5", "armed entry to multiplier", div_o, 0);
        gap(g);
        check(g == 2, "R2", "2x period", g, 2);

        // R8 writes ignored in multiplier mode
        wr_en(1'b0);
        check(mul_en_o && mul_ready_o, "R8", "enable held in multiplier mode",
              {mul_en_o, mul_ready_o}, 3);
        wr_sel(1'b1);
        check(!sel4x_o, "R8", "select held while enabled", sel4x_o, 0);
        wr_div(2'b11);
        check(div_o == 2'b00, "R4", "00 to 11 rejected", div_o, 0);
        wr_div(2'b10);
        check(div_o == 2'b10, "R5", "leave multiplier without steps", div_o, 2);
        gap(g);
        check(g == 4, "R5", "period after leaving multiplier", g, 4);

        // R2 4x arming
        arm(1'b1);
        wr_div(2'b00);
        gap(g);
        check(g == 1 && sel4x_o, "R2", "4x period", g, 1);
        wr_div(2'b10);

        // R7 clearing the enable drops ready
        wr_en(1'b0);
        @(negedge clk);
        check(!mul_ready_o, "R7", "ready cleared", mul_ready_o, 1'b0);

        // R6 skipped select step
        wr_en(1'b0);
        wr_en(1'b1);
        wait_ready(k);
        wr_div(2'b00);
        check(div_o == 2'b10, "R6", "missing select step rejected", div_o, 2);
        wr_sel(1'b0);
        check(sel4x_o, "R8", "select write ignored while enabled", sel4x_o, 1);

        // R6 regeneration mode interrupts arming
        wr_en(1'b0);
        wr_sel(1'b0);
        wr_en(1'b1);
        wait_ready(k);
        @(negedge clk); regen_i = 1'b1;
        @(negedge clk); regen_i = 1'b0;
        wr_div(2'b00);
        check(div_o == 2'b10, "R6", "regen pulse rejected entry", div_o, 2);

        // R5 early request before ready, then accepted once ready
        wr_en(1'b0);
        wr_sel(1'b0);
        wr_en(1'b1);
        wr_div(2'b00);
        check(div_o == 2'b10, "R5", "entry before ready rejected", div_o, 2);
        wait_ready(k);
        wr_div(2'b00);
        check(div_o == 2'b00, "R5", "entry after ready accepted", div_o, 0);
        gap(g);
        check(g == 2, "R2", "2x period after late entry", g, 2);
        wr_div(2'b10);

        summary();
        $finish;
    end

endmodule